// File: doc/BRIEF.md
# Recursive Approximate Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product without any clock. It works entirely in 2x2-bit pieces: both operands are cut into 2-bit digits, every digit pair gets its own small 2x2 cell, and the 4-bit cell outputs are moved to their bit weight and added exactly. N is a power of two no smaller than 2, which gives (N/2)² cells. With N = 2 there is one cell and no adder.

Each cell position is configured separately by a parameter. A position can hold the exact 2x2 product or one of four cheaper approximate cells. Each approximate cell drops or merges some of the carry logic of the exact one. A mix of exact cells in the high-weight positions and approximate cells in the low-weight positions trades accuracy for area and logic depth. When the configuration is left all zero, the block is an ordinary exact multiplier.

The block has no flow control. The product is a pure function of the current operands and follows them within the same cycle. The block carries no valid/ready handshake. A stream wrapper, if one is needed, forwards its handshake alongside the data unchanged.

Top module: `amul_recursive`

## Requirements
- R1: Cell (i, j) takes operand A bits [2i+1:2i] and operand B bits [2j+1:2j]. Its 4-bit result is shifted left by 2(i+j) bits, and all shifted results are summed exactly, modulo 2^(2N), into the product.
- R2: With every cell exact, the product equals opnd_a × opnd_b for all operand values.
- R3: Write the four partial bits of a cell as p00 = a0·b0, p01 = a0·b1, p10 = a1·b0 and p11 = a1·b1, and let c = p10·p01. The exact cell then gives {p11·c, p11⊕c, p10⊕p01, p00} (bit 3 down to bit 0).
- R4: Mode code 1 (truncated OR cell) gives {0, p11, p10|p01, p00}.
- R5: Mode code 3 (split-top cell) gives {p11·p00, p11·!p00, p10|p01, p00}. Its two upper bits are therefore never both 1.
- R6: Mode code 2 (no-corner cell) ignores p00. With t = p10·p01 it gives {t, p11⊕t, p10⊕p01, t}, so bit 0 always equals bit 3.
- R7: Mode code 4 (truncated XOR cell) gives {0, p11, p10⊕p01, p00}.
- R8: Each cell's mode comes from the 3-bit field CELL_MODES[3k+2:3k], with k = i·(N/2) + j. Code 0 selects the exact cell, and codes 5, 6 and 7 also select the exact cell.
- R9: With N = 2 the product is the output of the single cell.
- R10: In every configuration, a zero on either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | Unsigned multiplicand |
| opnd_b | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product, exact or approximate according to CELL_MODES |

## Verification
The assertions assume that both operands carry known 0/1 values, and they are skipped whenever any operand bit is unknown. They are immediate checks on settled combinational values, so they also assume the operands stay steady while they are evaluated. The bench drives only defined values, changes them on the falling clock edge and samples one nanosecond after the rising edge, so every comparison sees settled logic.

// File: rtl/amul_pkg.sv
package amul_pkg;

  typedef enum logic [2:0] {
    CELL_EXACT     = 3'd0,
    CELL_OR_TRUNC  = 3'd1,
    CELL_NO_CORNER = 3'd2,
    CELL_SPLIT_TOP = 3'd3,
    CELL_XOR_TRUNC = 3'd4
  } cell_kind_e;

  // Codes above 4 fall back to the exact cell (R8)
  function automatic cell_kind_e kind_of(logic [2:0] code);
    case (code)
      3'd1:    return CELL_OR_TRUNC;
      3'd2:    return CELL_NO_CORNER;
      3'd3:    return CELL_SPLIT_TOP;
      3'd4:    return CELL_XOR_TRUNC;
      default: return CELL_EXACT;
    endcase
  endfunction

endpackage

// File: rtl/amul_cell.sv
module amul_cell #(
  parameter logic [2:0] MODE = 3'd0
) (
  input  logic [1:0] a2,
  input  logic [1:0] b2,
  output logic [3:0] res
);
  import amul_pkg::*;
  localparam cell_kind_e KIND = kind_of(MODE);

  logic p01, p10, p11;
  assign p01 = a2[0] & b2[1];
  assign p10 = a2[1] & b2[0];
  assign p11 = a2[1] & b2[1];

  generate
    case (KIND)
      CELL_OR_TRUNC: begin : g_or_trunc
        assign res = {1'b0, p11, p10 | p01, a2[0] & b2[0]};
      end
      CELL_NO_CORNER: begin : g_no_corner
        logic t;
        assign t   = p10 & p01;
        assign res = {t, p11 ^ t, p10 ^ p01, t};
      end
      CELL_SPLIT_TOP: begin : g_split_top
        logic p00;
        assign p00 = a2[0] & b2[0];
        assign res = {p11 & p00, p11 & ~p00, p10 | p01, p00};
      end
      CELL_XOR_TRUNC: begin : g_xor_trunc
        assign res = {1'b0, p11, p10 ^ p01, a2[0] & b2[0]};
      end
      default: begin : g_exact
        logic c;
        assign c   = p10 & p01;
        assign res = {p11 & c, p11 ^ c, p10 ^ p01, a2[0] & b2[0]};
      end
    endcase
  endgenerate

endmodule

// File: rtl/amul_sum.sv
module amul_sum #(
  parameter int W   = 16,
  parameter int CNT = 16
) (
  input  logic [W-1:0] terms [CNT],
  output logic [W-1:0] total
);
  always_comb begin
    total = '0;
    for (int k = 0; k < CNT; k++) begin
      total = total + terms[k];
    end
  end
endmodule

// File: rtl/amul_recursive.sv
module amul_recursive #(
  parameter int N = 8,
  parameter logic [3*(N/2)*(N/2)-1:0] CELL_MODES = '0
) (
  input  logic [N-1:0]   opnd_a,
  input  logic [N-1:0]   opnd_b,
  output logic [2*N-1:0] product
);
  localparam int H     = N / 2;
  localparam int CELLS = H * H;
  localparam int W     = 2 * N;

  logic [3:0]   cell_res [CELLS];
  logic [W-1:0] placed   [CELLS];

  for (genvar i = 0; i < H; i++) begin : g_row
    for (genvar j = 0; j < H; j++) begin : g_col
      localparam int K = i * H + j;
      amul_cell #(.MODE(CELL_MODES[3*K +: 3])) u_cell (
        .a2  (opnd_a[2*i +: 2]),
        .b2  (opnd_b[2*j +: 2]),
        .res (cell_res[K])
      );
      assign placed[K] = W'(cell_res[K]) << (2 * (i + j));
    end
  end

  amul_sum #(.W(W), .CNT(CELLS)) u_sum (
    .terms (placed),
    .total (product)
  );

endmodule

// File: rtl/amul_recursive_chk.sv
module amul_recursive_chk #(
  parameter int N = 8,
  parameter logic [3*(N/2)*(N/2)-1:0] CELL_MODES = '0
) (
  input logic [N-1:0]   opnd_a,
  input logic [N-1:0]   opnd_b,
  input logic [2*N-1:0] product,
  input logic [3:0]     cell_res [(N/2)*(N/2)]
);
  localparam int H     = N / 2;
  localparam int CELLS = H * H;

  function automatic bit all_exact();
    for (int k = 0; k < CELLS; k++) begin
      if (CELL_MODES[3*k +: 3] inside {3'd1, 3'd2, 3'd3, 3'd4}) return 1'b0;
    end
    return 1'b1;
  endfunction
  localparam bit ALL_EXACT = all_exact();

  logic known;
  assign known = !$isunknown({opnd_a, opnd_b});

  always_comb begin
    if (known) begin
      AST_ZERO_OPERAND: assert (!((opnd_a == '0) || (opnd_b == '0)) || (product == '0)) else $error("zero operand"); // R10
      if (ALL_EXACT) begin
        AST_EXACT_PRODUCT: assert (product == (2*N)'(opnd_a) * (2*N)'(opnd_b)) else $error("exact product"); // R2
      end
    end
  end

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    localparam logic [2:0] CODE = CELL_MODES[3*k +: 3];
    localparam int I = k / H;
    localparam int J = k % H;
    always_comb begin
      if (known) begin
        if (!(CODE inside {3'd1, 3'd2, 3'd3, 3'd4})) begin
          AST_EXACT_CELL: assert (cell_res[k] == 4'(opnd_a[2*I +: 2]) * 4'(opnd_b[2*J +: 2])) else $error("exact cell"); // R3
        end
        if (CODE == 3'd1 || CODE == 3'd4) begin
          AST_TRUNC_TOP: assert (cell_res[k][3] == 1'b0) else $error("truncated top"); // R4
        end
        if (CODE == 3'd3) begin
          AST_SPLIT_EXCL: assert (!(cell_res[k][3] && cell_res[k][2])) else $error("split top"); // R5
        end
        if (CODE == 3'd2) begin
          AST_CORNER_MIRROR: assert (cell_res[k][0] == cell_res[k][3]) else $error("no corner"); // R6
        end
      end
    end
  end

endmodule

bind amul_recursive amul_recursive_chk #(.N(N), .CELL_MODES(CELL_MODES)) u_chk (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .product  (product),
  .cell_res (cell_res)
);

// File: tb/amul_recursive_test.sv
`timescale 1ns/1ps
module amul_recursive_test;

  localparam logic [11:0] MX_MODES = {3'd4, 3'd3, 3'd2, 3'd1};
  localparam logic [47:0] W_MODES  = 48'hFAC688FAC688;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [3:0]  a4, b4;
  logic [7:0]  p4, p4mx;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [1:0]  a2, b2;
  logic [3:0]  p2;

  amul_recursive #(.N(4)) uut (.opnd_a(a4), .opnd_b(b4), .product(p4));
  amul_recursive #(.N(4), .CELL_MODES(MX_MODES)) uut_mx (.opnd_a(a4), .opnd_b(b4), .product(p4mx));
  amul_recursive #(.N(8), .CELL_MODES(W_MODES)) uut_w (.opnd_a(a8), .opnd_b(b8), .product(p8));
  amul_recursive #(.N(2), .CELL_MODES(3'd2)) uut_n2 (.opnd_a(a2), .opnd_b(b2), .product(p2));

  function automatic logic [3:0] cell_ref(logic [2:0] code, logic [1:0] a, logic [1:0] b);
    logic p00, p01, p10, p11, c;
    p00 = a[0] & b[0]; p01 = a[0] & b[1];
    p10 = a[1] & b[0]; p11 = a[1] & b[1];
    c = p10 & p01;
    case (code)
      3'd1:    return {1'b0, p11, p10 | p01, p00};
      3'd2:    return {c, p11 ^ c, p10 ^ p01, c};
      3'd3:    return {p11 & p00, p11 & ~p00, p10 | p01, p00};
      3'd4:    return {1'b0, p11, p10 ^ p01, p00};
      default: return {p11 & c, p11 ^ c, p10 ^ p01, p00};
    endcase
  endfunction

  function automatic logic [31:0] model(int n, logic [47:0] modes, logic [15:0] a, logic [15:0] b);
    logic [63:0] acc;
    int h;
    h = n / 2;
    acc = '0;
    for (int i = 0; i < h; i++) begin
      for (int j = 0; j < h; j++) begin
        acc = acc + (64'(cell_ref(modes[3*(i*h+j) +: 3], a[2*i +: 2], b[2*j +: 2])) << (2*(i+j)));
      end
    end
    acc = acc & ((64'd1 << (2*n)) - 64'd1);
    return acc[31:0];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic settle;
    @(posedge clk);
    #1;
  endtask

  task automatic run_n4(logic [3:0] a, logic [3:0] b);
    @(negedge clk);
    a4 = a; b4 = b;
    settle();
    check("R2 exact N=4", 32'(p4), 32'(a) * 32'(b));
    check("R1 R4 R5 R6 R7 mixed N=4", 32'(p4mx), model(4, 48'(MX_MODES), 16'(a), 16'(b)));
  endtask

  task automatic run_n8(logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    a8 = a; b8 = b;
    settle();
    check("R1 R8 mixed N=8", 32'(p8), model(8, W_MODES, 16'(a), 16'(b)));
    if (a == 0 || b == 0) check("R10 zero N=8", 32'(p8), 32'd0);
  endtask

  initial begin
    a4 = '0; b4 = '0; a8 = '0; b8 = '0; a2 = '0; b2 = '0;
    void'($urandom(32'd20240408));
    settle();
    // idle state after start: all operands zero
    check("R10 start N=4", 32'(p4), 32'd0);
    check("R10 start N=8", 32'(p8), 32'd0);

    // exhaustive N=4: exact and one-of-each approximate cell
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) run_n4(4'(a), 4'(b));
    end
    // directed hand-computed values for 3x3 digit patterns
    @(negedge clk); a4 = 4'h3; b4 = 4'h3; settle();
    check("R2 3x3 exact", 32'(p4), 32'd9);
    // cell0 is M1: 3x3 -> 0111
    check("R4 3x3 truncated OR cell", 32'(p4mx), 32'd7);
    @(negedge clk); a4 = 4'hF; b4 = 4'hF; settle();
    check("R2 15x15 exact", 32'(p4), 32'd225);

    // exhaustive N=2 with the no-corner cell
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        @(negedge clk); a2 = 2'(a); b2 = 2'(b); settle();
        check("R9 R6 single cell", 32'(p2), 32'(cell_ref(3'd2, 2'(a), 2'(b))));
      end
    end
    @(negedge clk); a2 = 2'd1; b2 = 2'd1; settle();
    check("R6 corner ignored 1x1", 32'(p2), 32'd0);

    // N=8 with codes 0..7 per cell, including codes 5..7 as exact
    run_n8(8'h00, 8'hFF);
    run_n8(8'hFF, 8'h00);
    run_n8(8'hFF, 8'hFF);
    run_n8(8'h55, 8'hAA);
    run_n8(8'h80, 8'h01);
    run_n8(8'h03, 8'h03);
    for (int r = 0; r < 3000; r++) run_n8(8'($urandom), 8'($urandom));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule